// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus interface and an instruction execution unit and lets instruction fetch run ahead of execution. The bus side delivers 16-bit words read from memory at the current fetch pointer. When the pointer is even, both bytes of the word enter the queue. When the pointer is odd, only the upper byte enters. The pointer then advances by the number of bytes taken. The bus side only asks for another word when the queue reports room for at least two bytes.

The execution side sees the six oldest bytes in parallel, in the order they were fetched, together with a count of how many of them are valid. In one cycle it may remove from one to six bytes, which matches the length of one instruction. A push and a pop may happen in the same cycle. A flush input, used after a control transfer, empties the queue and loads a new fetch pointer. A flush overrides any push or pop in the same cycle.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset the valid count is 0, every head byte reads 0x00, the fetch pointer equals the parameter RST_ADDR (default 0), and `room_o` is 1.
- R2: `room_o` is 1 exactly when the valid count is at most DEPTH-2, that is, when at least two of the six byte slots are free.
- R3: The valid count never exceeds DEPTH (6). A push request while `room_o` is 0 is ignored: no byte is stored and the fetch pointer does not move.
- R4: An accepted push at an even fetch pointer stores two bytes, first bits 7:0 and then bits 15:8 of `fetch_word_i`, and advances the pointer by 2.
- R5: An accepted push at an odd fetch pointer (bit 0 = 1) stores only bits 15:8 of `fetch_word_i` and advances the pointer by 1.
- R6: A pop of n bytes (1 to 6), with n no greater than the valid count, removes the n oldest bytes. The remaining bytes move toward the head with their order kept. Head byte k is at bits 8k+7:8k of `head_bytes_o`, and byte 0 is the oldest.
- R7: A pop of 0 changes nothing. A pop larger than the valid count (including 7) is ignored as a whole.
- R8: When a push and a pop are accepted in the same cycle, the new count is old count + pushed - popped. The pushed bytes follow the bytes that remain. Whether the push is accepted depends on the count before the pop.
- R9: When `flush_i` is high, the next count is 0, the fetch pointer becomes `flush_addr_i`, and any push or pop in that cycle is ignored.
- R10: Head byte positions at or above the valid count read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the queue and reload the fetch pointer |
| flush_addr_i | input | ADDR_W | New fetch pointer loaded on flush |
| push_i | input | 1 | A fetched word is offered this cycle |
| fetch_word_i | input | 16 | Word read from memory at `fetch_addr_o` |
| pop_cnt_i | input | 3 | Number of bytes to remove (0 = none) |
| fetch_addr_o | output | ADDR_W | Current fetch pointer |
| room_o | output | 1 | At least two byte slots are free |
| head_bytes_o | output | 8*DEPTH | Oldest bytes, byte 0 in bits 7:0 |
| valid_cnt_o | output | 3 | Number of valid head bytes |

## Verification
The queue is filled from even pointers until it is full. This shows that the low byte is stored before the high byte and that the full condition blocks the next push. A push from an odd pointer after a flush shows that only the high byte enters and that the pointer advances by one. Pops of 0, of more than the valid count, of part of the queue and of all six bytes show the difference between an ignored request and a shift that keeps byte order. A push and a pop in the same cycle, once at count 4 and once at count 5, show that push acceptance depends on the count before the pop. A flush issued together with a push and a pop shows that the flush takes priority.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/pq_push_align.sv
module pq_push_align
  import pq_pkg::*;
(
  input  logic [15:0] word_i,
  input  logic        odd_i,
  output logic [1:0]  len_o,
  output byte_t       b0_o,
  output byte_t       b1_o
);
  always_comb begin
    if (odd_i) begin
      len_o = 2'd1;
      b0_o  = word_i[15:8];
      b1_o  = '0;
    end else begin
      len_o = 2'd2;
      b0_o  = word_i[7:0];
      b1_o  = word_i[15:8];
    end
  end
endmodule

// File: rtl/pq_fetch_ptr.sv
module pq_fetch_ptr #(
  parameter int unsigned ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [1:0]        adv_len_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_i || (adv_len_i != 2'd0);
    if (load_i) addr_d = load_addr_i;
    else        addr_d = addr_q + ADDR_W'(adv_len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= RST_ADDR;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pq_store.sv
module pq_store
  import pq_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(2 * DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [CNT_W-1:0]   pop_n_i,
  input  logic [1:0]         push_n_i,
  input  byte_t              b0_i,
  input  byte_t              b1_i,
  output logic [8*DEPTH-1:0] bytes_o,
  output logic [CNT_W-1:0]   count_o
);
  byte_t            slot_q [DEPTH];
  byte_t            slot_d [DEPTH];
  byte_t            ext    [2*DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;
  logic [CNT_W-1:0] rem;

  always_comb begin
    for (int j = 0; j < 2 * DEPTH; j++) begin
      ext[j] = (j < DEPTH) ? slot_q[j] : '0;
    end
    rem   = cnt_q - pop_n_i;
    en    = clr_i || (pop_n_i != '0) || (push_n_i != 2'd0);
    cnt_d = clr_i ? '0 : CNT_W'(rem + CNT_W'(push_n_i));
    for (int i = 0; i < DEPTH; i++) begin
      logic [IDX_W-1:0] src;
      src = IDX_W'(i) + IDX_W'(pop_n_i);
      if (clr_i)                                         slot_d[i] = '0;
      else if (CNT_W'(i) < rem)                          slot_d[i] = ext[src];
      else if (CNT_W'(i) == rem && push_n_i != 2'd0)     slot_d[i] = b0_i;
      else if (CNT_W'(i) == rem + 1'b1 && push_n_i == 2'd2) slot_d[i] = b1_i;
      else                                               slot_d[i] = '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[g] <= '0;
      else if (en) slot_q[g] <= slot_d[g];
    end
    assign bytes_o[8*g +: 8] = slot_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
  import pq_pkg::*;
#(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [ADDR_W-1:0]  flush_addr_i,
  input  logic               push_i,
  input  logic [15:0]        fetch_word_i,
  input  logic [CNT_W-1:0]   pop_cnt_i,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic               room_o,
  output logic [8*DEPTH-1:0] head_bytes_o,
  output logic [CNT_W-1:0]   valid_cnt_o
);
  logic [1:0]       word_len;
  byte_t            nb0, nb1;
  logic             push_ok, pop_ok;
  logic [1:0]       push_n;
  logic [CNT_W-1:0] pop_n;

  pq_push_align u_align (
    .word_i (fetch_word_i),
    .odd_i  (fetch_addr_o[0]),
    .len_o  (word_len),
    .b0_o   (nb0),
    .b1_o   (nb1)
  );

  always_comb begin
    room_o  = (valid_cnt_o <= CNT_W'(DEPTH - WORD_BYTES));
    push_ok = push_i && room_o && !flush_i;
    pop_ok  = !flush_i && (pop_cnt_i != '0) && (pop_cnt_i <= valid_cnt_o);
    push_n  = push_ok ? word_len : 2'd0;
    pop_n   = pop_ok ? pop_cnt_i : '0;
  end

  pq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (flush_i),
    .pop_n_i  (pop_n),
    .push_n_i (push_n),
    .b0_i     (nb0),
    .b1_i     (nb1),
    .bytes_o  (head_bytes_o),
    .count_o  (valid_cnt_o)
  );

  pq_fetch_ptr #(.ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (flush_i),
    .load_addr_i (flush_addr_i),
    .adv_len_i   (push_n),
    .addr_o      (fetch_addr_o)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic [ADDR_W-1:0]  flush_addr_i,
  input logic               push_i,
  input logic [CNT_W-1:0]   pop_cnt_i,
  input logic [ADDR_W-1:0]  fetch_addr_o,
  input logic               room_o,
  input logic [8*DEPTH-1:0] head_bytes_o,
  input logic [CNT_W-1:0]   valid_cnt_o
);
  logic [8*DEPTH-1:0] shifted;
  logic               tail_zero;

  always_comb begin
    shifted   = head_bytes_o >> {pop_cnt_i, 3'b000};
    tail_zero = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) >= valid_cnt_o && head_bytes_o[8*k +: 8] != 8'h00) tail_zero = 1'b0;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_cnt_o <= CNT_W'(DEPTH));

  assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !room_o && !flush_i && pop_cnt_i == '0) |=> ($stable(valid_cnt_o) && $stable(fetch_addr_o)));

  assert_even_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && room_o && !flush_i && !fetch_addr_o[0]) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2));

  assert_odd_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && room_o && !flush_i && fetch_addr_o[0]) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(1));

  assert_pop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && pop_cnt_i != '0 && pop_cnt_i < valid_cnt_o) |=> head_bytes_o[7:0] == $past(shifted[7:0]));

  assert_overpop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !push_i && pop_cnt_i > valid_cnt_o) |=> ($stable(valid_cnt_o) && $stable(head_bytes_o)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_cnt_o == '0 && fetch_addr_o == $past(flush_addr_i)));

  assert_tail_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tail_zero);
endmodule

bind prefetch_byte_queue pq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush_i      (flush_i),
  .flush_addr_i (flush_addr_i),
  .push_i       (push_i),
  .pop_cnt_i    (pop_cnt_i),
  .fetch_addr_o (fetch_addr_o),
  .room_o       (room_o),
  .head_bytes_o (head_bytes_o),
  .valid_cnt_o  (valid_cnt_o)
);

// File: tb/tb_prefetch_byte_queue.sv
`timescale 1ns/1ps
module tb_prefetch_byte_queue;
  localparam int DEPTH  = 6;
  localparam int ADDR_W = 20;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               flush_i;
  logic [ADDR_W-1:0]  flush_addr_i;
  logic               push_i;
  logic [15:0]        fetch_word_i;
  logic [2:0]         pop_cnt_i;
  logic [ADDR_W-1:0]  fetch_addr_o;
  logic               room_o;
  logic [8*DEPTH-1:0] head_bytes_o;
  logic [2:0]         valid_cnt_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0]        exp_q[$];
  logic [ADDR_W-1:0] exp_addr;

  always #5 clk = ~clk;

  prefetch_byte_queue dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .push_i(push_i), .fetch_word_i(fetch_word_i), .pop_cnt_i(pop_cnt_i),
    .fetch_addr_o(fetch_addr_o), .room_o(room_o), .head_bytes_o(head_bytes_o),
    .valid_cnt_o(valid_cnt_o)
  );

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    logic [8*DEPTH-1:0] hv;
    hv = '0;
    foreach (exp_q[k]) hv[8*k +: 8] = exp_q[k];
    chk(valid_cnt_o == 3'(exp_q.size()), tag, "count", 64'(valid_cnt_o), 64'(exp_q.size()));
    chk(head_bytes_o == hv, tag, "head", 64'(head_bytes_o), 64'(hv));
    chk(fetch_addr_o == exp_addr, tag, "addr", 64'(fetch_addr_o), 64'(exp_addr));
    chk(room_o == (exp_q.size() <= DEPTH - 2), tag, "room", 64'(room_o), 64'(exp_q.size() <= DEPTH - 2));
  endtask

  // Driver: applies one cycle of stimulus and updates the scoreboard model.
  task automatic step(bit p, logic [15:0] w, int pc, bit f, logic [ADDR_W-1:0] fa, string tag);
    bit room, pop_ok;
    @(negedge clk);
    push_i = p; fetch_word_i = w; pop_cnt_i = 3'(pc); flush_i = f; flush_addr_i = fa;
    if (f) begin
      exp_q.delete();
      exp_addr = fa;
    end else begin
      room   = exp_q.size() <= DEPTH - 2;
      pop_ok = pc != 0 && pc <= exp_q.size();
      if (pop_ok) repeat (pc) void'(exp_q.pop_front());
      if (p && room) begin
        if (exp_addr[0]) begin
          exp_q.push_back(w[15:8]);
          exp_addr = exp_addr + 1;
        end else begin
          exp_q.push_back(w[7:0]);
          exp_q.push_back(w[15:8]);
          exp_addr = exp_addr + 2;
        end
      end
    end
    @(posedge clk);
    #2;
    push_i = 0; pop_cnt_i = 0; flush_i = 0;
    check_state(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush_i = 0; flush_addr_i = '0; push_i = 0; fetch_word_i = '0; pop_cnt_i = 0;
    exp_addr = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check_state("R1");
    check_state("R10");

    step(1, 16'h2211, 0, 0, '0, "R4");
    step(1, 16'h4433, 0, 0, '0, "R4");
    step(1, 16'h6655, 0, 0, '0, "R2");
    step(1, 16'h8877, 0, 0, '0, "R3");
    step(0, 16'h0000, 7, 0, '0, "R7");
    step(0, 16'h0000, 0, 0, '0, "R7");
    step(0, 16'h0000, 2, 0, '0, "R6");
    step(1, 16'hAA99, 1, 0, '0, "R8");
    step(1, 16'hCCBB, 3, 0, '0, "R3");
    step(1, 16'h1234, 1, 1, 20'h00013, "R9");
    step(1, 16'hBBCC, 0, 0, '0, "R5");
    step(1, 16'hDDEE, 0, 0, '0, "R4");
    step(0, 16'h0000, 5, 0, '0, "R7");
    step(0, 16'h0000, 1, 0, '0, "R10");
    step(1, 16'h5A6B, 2, 0, '0, "R8");
    step(1, 16'h0102, 0, 0, '0, "R4");
    step(1, 16'h0304, 0, 0, '0, "R4");
    step(0, 16'h0000, 6, 0, '0, "R6");
    step(1, 16'h0506, 0, 0, '0, "R4");
    step(0, 16'h0000, 1, 1, 20'hFFFFE, "R9");
    step(1, 16'h7788, 0, 0, '0, "R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule